// File: doc/BRIEF.md
# Cascaded Interrupt Request and Vector Arbiter

This block handles the request side and the vector side of a pair of eight-line interrupt controllers. One controller is the primary and the other is the secondary, which feeds into it. A request carries a number from 0 to 15. Numbers 0–7 go to primary line `n`, numbers 8–15 go to secondary line `n-8`, and anything above is discarded.

Each request is tested against the mask and in-service words of its controller. Secondary requests are also tested against the cascade wiring and the primary's in-service state. A request that passes sets a bit in that controller's pending register. The single CPU interrupt line stays high while any pending bit is set.

When the CPU strobes acknowledge, the block picks the highest-priority pending line and returns an 8-bit vector one cycle later. Primary lines come first, and lower indices win within a controller. The mask, in-service, base, cascade and auto-EOI settings come from external configuration registers. The block reports in-service updates as one-cycle set pulses, which the owner of those registers ORs in.

Top module: `cascade_irq_arbiter`

## Requirements
- R1: After reset, both pending registers are empty, `irqOut` and `vecValid` are 0, and both in-service pulse outputs are 0.
- R2: A request numbered 0–7 sets primary pending bit `reqNum` unless that bit is set in `priMask` or `priInService`. `irqOut` reads 1 in the cycle after an accepted request.
- R3: A request numbered 8–15 targets secondary line `reqNum-8` and is dropped if that line is set in `secMask` or `secInService`. Numbers 16–31 change nothing.
- R4: A secondary request is dropped unless `priCascade` bit 2 is 1 and `secCascade` equals 2.
- R5: A secondary request is dropped while any bit of `priInService` is 1.
- R6: An accepted secondary request with `priAutoEoi` = 0 pulses `priIsrSet` = 8'h04 for one cycle, starting the cycle after the request. With `priAutoEoi` = 1 there is no pulse.
- R7: On `ackStrobe` with any primary bit pending, the lowest pending index `i` is cleared. In the next cycle `vecValid` = 1 and `vecNum` = `priBase + i`, and `priIsrSet` carries bit `i` unless `priAutoEoi` is 1.
- R8: On `ackStrobe` with no primary bit pending, the lowest pending secondary index `i` is cleared and the vector is `secBase + i`. `secIsrSet` carries bit `i` unless `secAutoEoi` is 1.
- R9: If the selected secondary index is 1 and `secCascadeSet` is 1, the vector is `priBase + secCascade` and `secIsrSet` stays 0.
- R10: On `ackStrobe` with nothing pending, the vector is `secBase + 7` if `priInService` bit 2 is 1, and `priBase + 7` otherwise. Neither in-service pulse fires.
- R11: A request with signed `reqCount` ≤ 0 has no effect. Any count ≥ 1 has the same effect as one application, with at most one `priIsrSet` pulse.
- R12: `irqOut` is 1 while any pending bit in either controller is set, and returns to 0 in the cycle after the acknowledge that empties both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request command strobe |
| reqNum | input | 5 | Request number (0–7 primary, 8–15 secondary, above ignored) |
| reqCount | input | 4 | Signed repeat count of the request command |
| ackStrobe | input | 1 | One-cycle interrupt acknowledge from the CPU |
| priMask | input | 8 | Primary mask word |
| secMask | input | 8 | Secondary mask word |
| priInService | input | 8 | Primary in-service word |
| secInService | input | 8 | Secondary in-service word |
| priBase | input | 8 | Primary vector base |
| secBase | input | 8 | Secondary vector base |
| priCascade | input | 8 | Primary cascade word (bit per line with a secondary) |
| secCascade | input | 8 | Secondary cascade word (its identity) |
| secCascadeSet | input | 1 | Secondary cascade word has been loaded |
| priAutoEoi | input | 1 | Primary auto end-of-interrupt mode |
| secAutoEoi | input | 1 | Secondary auto end-of-interrupt mode |
| irqOut | output | 1 | Interrupt line to the CPU |
| vecValid | output | 1 | Vector valid, one cycle after acknowledge |
| vecNum | output | 8 | Vector number |
| priIsrSet | output | 8 | One-cycle set pulses for the primary in-service word |
| secIsrSet | output | 8 | One-cycle set pulses for the secondary in-service word |

## Verification
The bench targets these corner cases:

- **Priority order.** When lines are pending in both controllers, acknowledges must drain them primary-first and by ascending index. A reversed scan returns the wrong vectors.
- **Gating of secondary requests.** A broken cascade word or a busy primary must block them. A design that gated only on mask would raise `irqOut`.
- **The cascade-line exception and the spurious vectors.** The first returns `priBase + secCascade`; a design that treated line 1 as ordinary would return `secBase + 1` and pulse `secIsrSet`. For the spurious case, the base chosen depends on primary in-service bit 2.
- **Repeat counts and auto-EOI.** Zero and negative counts must leave the block silent. In auto-EOI mode, a design that still pulsed the in-service outputs is reported by the scoreboard.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int LINES    = 8;
  localparam int IDXW     = $clog2(LINES);
  localparam int VECW     = 8;
  localparam int REQW     = 5;
  localparam int CNTW     = 4;
  localparam int CASC_LINE = 2;

  typedef logic [LINES-1:0] lineVecT;

  typedef struct packed {
    lineVecT           priSet;
    lineVecT           secSet;
    lineVecT           priClr;
    lineVecT           secClr;
    logic              vecLoad;
    logic [VECW-1:0]   vecValue;
    lineVecT           priIsrPulse;
    lineVecT           secIsrPulse;
  } ctlStrobesT;

  function automatic logic [IDXW-1:0] lowestIdx(input lineVecT v);
    logic [IDXW-1:0] idx;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) idx = IDXW'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/cia_control.sv
module cia_control
  import cia_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [REQW-1:0]   reqNum,
  input  logic [CNTW-1:0]   reqCount,
  input  logic              ackStrobe,
  input  lineVecT           priMask,
  input  lineVecT           secMask,
  input  lineVecT           priInService,
  input  lineVecT           secInService,
  input  logic [VECW-1:0]   priBase,
  input  logic [VECW-1:0]   secBase,
  input  logic [VECW-1:0]   priCascade,
  input  logic [VECW-1:0]   secCascade,
  input  logic              secCascadeSet,
  input  logic              priAutoEoi,
  input  logic              secAutoEoi,
  input  lineVecT           priPending,
  input  lineVecT           secPending,
  output ctlStrobesT        ctl
);
  localparam logic [REQW-1:0] SEC_LO = REQW'(LINES);
  localparam logic [REQW-1:0] SEC_HI = REQW'(2 * LINES);

  logic            reqLive, toPri, toSec, cascadeOk, priAccept, secAccept;
  logic [IDXW-1:0] reqIdx, priIdx, secIdx;
  logic            priAny, secAny;

  always_comb begin
    reqLive   = reqValid && ($signed(reqCount) > 0);
    reqIdx    = reqNum[IDXW-1:0];
    toPri     = reqNum < SEC_LO;
    toSec     = (reqNum >= SEC_LO) && (reqNum < SEC_HI);
    cascadeOk = priCascade[CASC_LINE] && (secCascade == VECW'(CASC_LINE));
    priAccept = reqLive && toPri && !priInService[reqIdx] && !priMask[reqIdx];
    secAccept = reqLive && toSec && cascadeOk && (priInService == '0)
                && !secInService[reqIdx] && !secMask[reqIdx];

    priAny = |priPending;
    secAny = |secPending;
    priIdx = lowestIdx(priPending);
    secIdx = lowestIdx(secPending);

    ctl = '0;
    if (priAccept) ctl.priSet[reqIdx] = 1'b1;
    if (secAccept) begin
      ctl.secSet[reqIdx] = 1'b1;
      if (!priAutoEoi) ctl.priIsrPulse[CASC_LINE] = 1'b1;
    end

    if (ackStrobe) begin
      ctl.vecLoad = 1'b1;
      if (priAny) begin
        ctl.priClr[priIdx] = 1'b1;
        if (!priAutoEoi) ctl.priIsrPulse[priIdx] = 1'b1;
        ctl.vecValue = priBase + VECW'(priIdx);
      end else if (secAny) begin
        ctl.secClr[secIdx] = 1'b1;
        if ((secIdx == IDXW'(1)) && secCascadeSet) begin
          ctl.vecValue = priBase + secCascade;
        end else begin
          if (!secAutoEoi) ctl.secIsrPulse[secIdx] = 1'b1;
          ctl.vecValue = secBase + VECW'(secIdx);
        end
      end else if (priInService[CASC_LINE]) begin
        ctl.vecValue = secBase + VECW'(LINES - 1);
      end else begin
        ctl.vecValue = priBase + VECW'(LINES - 1);
      end
    end
  end

  // R5: secondary acceptance never happens with the primary busy
  a_r5_sec_blocked_by_pri: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.secSet != '0) |-> (priInService == '0));

  // R4: secondary acceptance requires a sane cascade configuration
  a_r4_cascade_gate: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.secSet != '0) |-> (priCascade[CASC_LINE] && secCascade == VECW'(CASC_LINE)));

  // R11: non-positive counts produce no pending update
  a_r11_count_gate: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(reqCount) <= 0) |-> (ctl.priSet == '0 && ctl.secSet == '0));
endmodule

// File: rtl/cia_datapath.sv
module cia_datapath
  import cia_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobesT      ctl,
  input  logic            reqValid,
  input  logic            ackStrobe,
  output lineVecT         priPending,
  output lineVecT         secPending,
  output logic            vecValid,
  output logic [VECW-1:0] vecNum,
  output lineVecT         priIsrSet,
  output lineVecT         secIsrSet
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priPending <= '0;
      secPending <= '0;
      vecValid   <= 1'b0;
      vecNum     <= '0;
      priIsrSet  <= '0;
      secIsrSet  <= '0;
    end else begin
      priPending <= (priPending & ~ctl.priClr) | ctl.priSet;
      secPending <= (secPending & ~ctl.secClr) | ctl.secSet;
      vecValid   <= ctl.vecLoad;
      if (ctl.vecLoad) vecNum <= ctl.vecValue;
      priIsrSet  <= ctl.priIsrPulse;
      secIsrSet  <= ctl.secIsrPulse;
    end
  end

  // R2: a new pending bit only appears after a request command
  a_r2_pending_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (((priPending & ~$past(priPending)) | (secPending & ~$past(secPending))) != '0)
      |-> $past(reqValid));

  // R7: the vector is valid exactly one cycle after acknowledge
  a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> vecValid);

  // R12: pending bits only drain through an acknowledge
  a_r12_drain_by_ack: assert property (@(posedge clk) disable iff (!rstN)
    (($past(priPending) & ~priPending) != '0) |-> $past(ackStrobe));

  // R6: at most one primary in-service pulse at a time
  a_r6_onehot_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(priIsrSet) && $onehot0(secIsrSet));
endmodule

// File: rtl/cascade_irq_arbiter.sv
module cascade_irq_arbiter
  import cia_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [4:0]      reqNum,
  input  logic [3:0]      reqCount,
  input  logic            ackStrobe,
  input  logic [7:0]      priMask,
  input  logic [7:0]      secMask,
  input  logic [7:0]      priInService,
  input  logic [7:0]      secInService,
  input  logic [7:0]      priBase,
  input  logic [7:0]      secBase,
  input  logic [7:0]      priCascade,
  input  logic [7:0]      secCascade,
  input  logic            secCascadeSet,
  input  logic            priAutoEoi,
  input  logic            secAutoEoi,
  output logic            irqOut,
  output logic            vecValid,
  output logic [7:0]      vecNum,
  output logic [7:0]      priIsrSet,
  output logic [7:0]      secIsrSet
);
  ctlStrobesT ctl;
  lineVecT    priPending, secPending;

  cia_control u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNum(reqNum),
    .reqCount(reqCount), .ackStrobe(ackStrobe), .priMask(priMask),
    .secMask(secMask), .priInService(priInService), .secInService(secInService),
    .priBase(priBase), .secBase(secBase), .priCascade(priCascade),
    .secCascade(secCascade), .secCascadeSet(secCascadeSet),
    .priAutoEoi(priAutoEoi), .secAutoEoi(secAutoEoi),
    .priPending(priPending), .secPending(secPending), .ctl(ctl)
  );

  cia_datapath u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqValid(reqValid),
    .ackStrobe(ackStrobe), .priPending(priPending), .secPending(secPending),
    .vecValid(vecValid), .vecNum(vecNum), .priIsrSet(priIsrSet),
    .secIsrSet(secIsrSet)
  );

  assign irqOut = (priPending != '0) || (secPending != '0);
endmodule

// File: tb/cascade_irq_arbiter_tb.sv
module cascade_irq_arbiter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, ackStrobe = 1'b0;
  logic [4:0] reqNum = '0;
  logic [3:0] reqCount = 4'd1;
  logic [7:0] priMask = '0, secMask = '0, priIsr = '0, secIsr = '0;
  logic [7:0] priBase = 8'h08, secBase = 8'h70;
  logic [7:0] priCascade = 8'h04, secCascade = 8'h02;
  logic secCascadeSet = 1'b0, priAutoEoi = 1'b0, secAutoEoi = 1'b0;
  logic irqOut, vecValid;
  logic [7:0] vecNum, priIsrSet, secIsrSet;
  int checks = 0, failures = 0;
  logic [23:0] expQ[$];
  logic [7:0] lastPriPulse;

  always #5 clk = ~clk;

  cascade_irq_arbiter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNum(reqNum),
    .reqCount(reqCount), .ackStrobe(ackStrobe), .priMask(priMask),
    .secMask(secMask), .priInService(priIsr), .secInService(secIsr),
    .priBase(priBase), .secBase(secBase), .priCascade(priCascade),
    .secCascade(secCascade), .secCascadeSet(secCascadeSet),
    .priAutoEoi(priAutoEoi), .secAutoEoi(secAutoEoi), .irqOut(irqOut),
    .vecValid(vecValid), .vecNum(vecNum), .priIsrSet(priIsrSet),
    .secIsrSet(secIsrSet)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one request command; captures the primary pulse seen next cycle.
  task automatic request(input int num, input int cnt);
    @(negedge clk);
    reqValid = 1'b1; reqNum = 5'(num); reqCount = 4'(cnt);
    @(negedge clk);
    reqValid = 1'b0; reqCount = 4'd1;
    lastPriPulse = priIsrSet;
    priIsr = priIsr | priIsrSet;
  endtask

  // Driver: acknowledge, pushing the expected {vector, priPulse, secPulse}.
  task automatic ack(input logic [7:0] v, input logic [7:0] pp, input logic [7:0] sp);
    expQ.push_back({v, pp, sp});
    @(negedge clk);
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares each produced vector against the scoreboard.
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) check("R7 unexpected vector", 32'(vecNum), 32'hFFFF);
      else begin
        logic [23:0] e;
        e = expQ.pop_front();
        check("R7/R8/R9/R10 vector", 32'(vecNum), 32'(e[23:16]));
        check("R7/R8/R9 priIsrSet", 32'(priIsrSet), 32'(e[15:8]));
        check("R8/R9 secIsrSet", 32'(secIsrSet), 32'(e[7:0]));
        priIsr = priIsr | priIsrSet;
        secIsr = secIsr | secIsrSet;
      end
    end
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 vecValid", 32'(vecValid), 0);
    check("R1 pulses", 32'({priIsrSet, secIsrSet}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10 spurious, primary base
    ack(8'h0F, 8'h00, 8'h00);
    // R2 / R7 priority and ISR pulses
    request(5, 1);
    check("R2 irqOut after accept", 32'(irqOut), 1);
    request(3, 1);
    ack(8'h0B, 8'h08, 8'h00);
    ack(8'h0D, 8'h20, 8'h00);
    check("R12 irqOut drops when empty", 32'(irqOut), 0);
    // R2 dropped by in-service (bit 3 still set)
    request(3, 1);
    check("R2 in-service drop", 32'(irqOut), 0);
    priIsr = '0;
    priMask = 8'h10;
    request(4, 1);
    check("R2 mask drop", 32'(irqOut), 0);
    priMask = '0;
    request(20, 1);
    check("R3 number above 15 ignored", 32'(irqOut), 0);
    secMask = 8'h20;
    request(13, 1);
    check("R3 secondary mask drop", 32'(irqOut), 0);
    secMask = '0;
    // R3 / R6 / R8 secondary path
    request(13, 1);
    check("R3 secondary accept", 32'(irqOut), 1);
    check("R6 priIsrSet on secondary accept", 32'(lastPriPulse), 8'h04);
    ack(8'h75, 8'h00, 8'h20);
    check("R12 irqOut after secondary drain", 32'(irqOut), 0);
    // R5 primary busy (bit 2 set by the pulse)
    request(10, 1);
    check("R5 primary busy drop", 32'(irqOut), 0);
    priIsr = '0; secIsr = '0;
    // R4 cascade gating
    secCascade = 8'h03;
    request(10, 1);
    check("R4 secondary id mismatch", 32'(irqOut), 0);
    secCascade = 8'h02; priCascade = 8'h00;
    request(10, 1);
    check("R4 primary cascade bit clear", 32'(irqOut), 0);
    priCascade = 8'h04;
    // R10 spurious with primary bit 2 in service
    priIsr = 8'h04;
    ack(8'h77, 8'h00, 8'h00);
    priIsr = '0;
    // R11 repeat counts
    request(1, 0);
    check("R11 zero count", 32'(irqOut), 0);
    request(1, -2);
    check("R11 negative count", 32'(irqOut), 0);
    request(14, 3);
    check("R11 count 3 accepted once", 32'(irqOut), 1);
    check("R11 single pulse", 32'(lastPriPulse), 8'h04);
    @(negedge clk);
    check("R11 no second pulse", 32'(priIsrSet), 0);
    ack(8'h76, 8'h00, 8'h40);
    priIsr = '0; secIsr = '0;
    // R9 cascade-line exception
    secCascadeSet = 1'b1;
    request(9, 1);
    ack(8'h0A, 8'h00, 8'h00);
    priIsr = '0; secIsr = '0; secCascadeSet = 1'b0;
    // R7 / R6 auto-EOI
    priAutoEoi = 1'b1;
    request(0, 1);
    ack(8'h08, 8'h00, 8'h00);
    request(12, 1);
    check("R6 no pulse in auto-EOI", 32'(lastPriPulse), 0);
    secAutoEoi = 1'b1;
    ack(8'h74, 8'h00, 8'h00);
    priAutoEoi = 1'b0; secAutoEoi = 1'b0;
    priIsr = '0; secIsr = '0;
    // R7 / R8 mixed priority: secondary first, then primaries 6 and 1
    request(11, 1);
    request(6, 1);
    request(1, 1);
    ack(8'h09, 8'h02, 8'h00);
    ack(8'h0E, 8'h40, 8'h00);
    ack(8'h73, 8'h00, 8'h08);
    check("R12 all drained", 32'(irqOut), 0);
    repeat (3) @(negedge clk);
    check("R7 scoreboard empty", 32'(expQ.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule